// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-facing side of a small telephony and audio controller. The host sees a byte-wide bus with a 3-bit offset. Offset 0 is a command port when written and an interrupt status port when read. Offset 1 is a data port. Offsets 2 to 7 have no function here. To reach an internal register, the host writes the register number to offset 0. It then reads or writes offset 1 once for each byte of that register. Two-byte registers are transferred low byte first. The block holds those registers and drives their contents onto plain output ports. It also collects eight interrupt sources into a pending byte, which clears when it is read.

A byte pointer state machine tracks each transfer. Its states are:
- IDX_NONE: after reset, no register is selected.
- IDX_LO: the next data access touches byte 0.
- IDX_HI: the next data access touches byte 1 of a two-byte register.
- IDX_END: the register's bytes are used up, or the number is unknown.

Its transitions are:
- `select`: any command write, from any state. It goes to IDX_LO for a known number and to IDX_END otherwise.
- `step_lo`: a data access in IDX_LO. It goes to IDX_HI for a two-byte register and to IDX_END for a one-byte register.
- `step_hi`: a data access in IDX_HI. It goes to IDX_END.
- `hold`: any other cycle. The state is unchanged.

Top module: `ireg_port`

## Requirements
- R1: After reset, all held registers are 0, no interrupt is pending, `irq_o` is 0, and a data-port read before any command returns 0.
- R2: A bus access takes one cycle with `bus_sel` high. Read data is valid in that same cycle. A write updates the output ports from the next cycle on.
- R3: The gain registers 0x63 (`gain_tx`), 0x64 (`gain_rx`), 0x65 (`gain_er`) and 0x66 (`gain_st`) are 16 bits wide. The first data access after selection touches bits 7:0 and the second touches bits 15:8.
- R4: A data access past a register's last byte has no effect when it is a write and returns 0 when it is a read. A new command write restarts the pointer at byte 0.
- R5: Data-port reads step through the register's bytes in the same order as writes do.
- R6: A register number outside {0x21, 0x41, 0x44, 0x63, 0x64, 0x65, 0x66, 0x69} ignores data writes and reads back 0.
- R7: A read at offset 0 returns the pending byte and clears it. The bit positions are: bit 0 D transmit threshold, 1 D receive threshold, 2 D packet status, 3 D error, 4 B-channel transfer, 5 line status, 6 D buffer status, 7 multiframe. A source pulse sets its bit.
- R8: A source that is high in the same cycle as an offset-0 read is still pending afterwards.
- R9: `irq_o` is high when any bit is pending and bit 2 of register 0x21 is 0.
- R10: Register 0x21 is one byte. Bits 1:0 drive `pwr_mode` (1 active, 2 data only, 3 power-down) and bit 2 drives `ints_off`.
- R11: Register 0x41 is one byte. Bits 3:0 drive `path_a` and bits 7:4 drive `path_b`, each a channel code from 1 to 8.
- R12: Register 0x44 is one byte. Bit 3 drives `bch_irq_en`, bit 4 drives `rev_bb` and bit 5 drives `rev_bc`.
- R13: Register 0x69 is one byte. Bit 0 drives `alaw_sel`. Bits 1, 2, 3 and 6 drive `gx_en`, `gr_en`, `ger_en` and `stg_en`. Bit 7 drives `loop_en`.
- R14: Accesses at offsets 2 to 7 change nothing and read 0. An offset-0 read leaves the register selection and the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Bus offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while the read strobe is high |
| irq_src | input | 8 | Interrupt source pulses |
| irq_o | output | 1 | Interrupt request |
| pwr_mode | output | 2 | Operating mode field |
| ints_off | output | 1 | Interrupt disable |
| path_a | output | 4 | First mux channel code |
| path_b | output | 4 | Second mux channel code |
| bch_irq_en | output | 1 | B-channel interrupt enable |
| rev_bb | output | 1 | Bit reversal on channel Bb |
| rev_bc | output | 1 | Bit reversal on channel Bc |
| alaw_sel | output | 1 | A-law (1) or mu-law (0) |
| gx_en | output | 1 | Transmit gain stage enable |
| gr_en | output | 1 | Receive gain stage enable |
| ger_en | output | 1 | Extra receive gain stage enable |
| stg_en | output | 1 | Side-tone gain stage enable |
| loop_en | output | 1 | Loopback enable |
| gain_tx | output | 16 | Transmit gain coefficient |
| gain_rx | output | 16 | Receive gain coefficient |
| gain_er | output | 16 | Extra receive gain coefficient |
| gain_st | output | 16 | Side-tone gain coefficient |

## Verification
The bench tries several access patterns:
- Single-byte and two-byte register programming with distinct byte values. This separates a low/high swap from a correct transfer.
- Surplus writes and reads after the last byte. These show whether the pointer saturates or wraps.
- A command rewrite midway through a two-byte transfer. This shows that the pointer restarts at byte 0.
- An interrupt-status read between two data bytes. This shows that the read disturbs neither the pointer nor the selection.
- Unknown register numbers and unused offsets. These must leave every output unchanged.
- A source pulse in the same cycle as a status read. This separates "clear then set" from a plain clear.
- Toggling the disable bit while bits are pending. This checks the gating of the request output.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_LO   = 2'd1,
        IDX_HI   = 2'd2,
        IDX_END  = 2'd3
    } idx_state_t;

    localparam logic [7:0] RN_INIT  = 8'h21;
    localparam logic [7:0] RN_MUX1  = 8'h41;
    localparam logic [7:0] RN_MUX4  = 8'h44;
    localparam logic [7:0] RN_GX    = 8'h63;
    localparam logic [7:0] RN_GR    = 8'h64;
    localparam logic [7:0] RN_GER   = 8'h65;
    localparam logic [7:0] RN_STG   = 8'h66;
    localparam logic [7:0] RN_MODE1 = 8'h69;

    function automatic logic [1:0] reg_bytes(input logic [7:0] num);
        logic [1:0] n;
        unique case (num)
            RN_INIT, RN_MUX1, RN_MUX4, RN_MODE1: n = 2'd1;
            RN_GX, RN_GR, RN_GER, RN_STG:        n = 2'd2;
            default:                             n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ireg_fsm.sv
module ireg_fsm
    import ireg_pkg::*;
#(
    parameter int NUMW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr,
    input  logic            data_acc,
    input  logic [NUMW-1:0] cmd_val,
    output logic [NUMW-1:0] sel_num,
    output logic            at_lo,
    output logic            at_hi
);

    idx_state_t state_q, state_d;
    logic [NUMW-1:0] num_q;

    always_comb begin
        state_d = state_q;
        if (cmd_wr) begin
            state_d = (reg_bytes(cmd_val) != 2'd0) ? IDX_LO : IDX_END;
        end else if (data_acc) begin
            unique case (state_q)
                IDX_NONE: state_d = IDX_NONE;
                IDX_LO:   state_d = (reg_bytes(num_q) == 2'd2) ? IDX_HI : IDX_END;
                IDX_HI:   state_d = IDX_END;
                IDX_END:  state_d = IDX_END;
                default:  state_d = IDX_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDX_NONE;
            num_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_wr) num_q <= cmd_val;
        end
    end

    always_comb begin
        at_lo = 1'b0;
        at_hi = 1'b0;
        unique case (state_q)
            IDX_LO:  at_lo = 1'b1;
            IDX_HI:  at_hi = 1'b1;
            default: ;
        endcase
    end

    assign sel_num = num_q;

    // R4: without a new command, a used-up register stays used up
    a_r4_end_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDX_END && !cmd_wr) |=> state_q == IDX_END);

    // R4: a command always restarts the pointer
    a_r4_cmd_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (state_q == IDX_LO || state_q == IDX_END));

    // R3: byte 1 is only reached straight from byte 0
    a_r3_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(at_hi) |-> $past(at_lo));

endmodule

// File: rtl/ireg_file.sv
module ireg_file
    import ireg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          at_lo,
    input  logic          at_hi,
    input  logic [7:0]    num,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_byte,
    output logic [DW-1:0] init_q,
    output logic [DW-1:0] mux1_q,
    output logic [DW-1:0] mux4_q,
    output logic [DW-1:0] mode1_q,
    output logic [2*DW-1:0] gx_q,
    output logic [2*DW-1:0] gr_q,
    output logic [2*DW-1:0] ger_q,
    output logic [2*DW-1:0] stg_q
);

    localparam int WW = 2 * DW;

    logic [WW-1:0] sel_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q  <= '0;
            mux1_q  <= '0;
            mux4_q  <= '0;
            mode1_q <= '0;
            gx_q    <= '0;
            gr_q    <= '0;
            ger_q   <= '0;
            stg_q   <= '0;
        end else if (wr_lo) begin
            unique case (num)
                RN_INIT:  init_q       <= wdata;
                RN_MUX1:  mux1_q       <= wdata;
                RN_MUX4:  mux4_q       <= wdata;
                RN_MODE1: mode1_q      <= wdata;
                RN_GX:    gx_q[DW-1:0]  <= wdata;
                RN_GR:    gr_q[DW-1:0]  <= wdata;
                RN_GER:   ger_q[DW-1:0] <= wdata;
                RN_STG:   stg_q[DW-1:0] <= wdata;
                default: ;
            endcase
        end else if (wr_hi) begin
            unique case (num)
                RN_GX:   gx_q[WW-1:DW]  <= wdata;
                RN_GR:   gr_q[WW-1:DW]  <= wdata;
                RN_GER:  ger_q[WW-1:DW] <= wdata;
                RN_STG:  stg_q[WW-1:DW] <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (num)
            RN_INIT:  sel_val = {{DW{1'b0}}, init_q};
            RN_MUX1:  sel_val = {{DW{1'b0}}, mux1_q};
            RN_MUX4:  sel_val = {{DW{1'b0}}, mux4_q};
            RN_MODE1: sel_val = {{DW{1'b0}}, mode1_q};
            RN_GX:    sel_val = gx_q;
            RN_GR:    sel_val = gr_q;
            RN_GER:   sel_val = ger_q;
            RN_STG:   sel_val = stg_q;
            default:  sel_val = '0;
        endcase
        if (at_lo)      rd_byte = sel_val[DW-1:0];
        else if (at_hi) rd_byte = sel_val[WW-1:DW];
        else            rd_byte = '0;
    end

    // R3: writing the high byte keeps the low byte
    a_r3_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && num == RN_GX) |=> gx_q[DW-1:0] == $past(gx_q[DW-1:0]));

    // R6: an unknown number never changes a held register
    a_r6_unknown_inert: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_lo || wr_hi) && reg_bytes(num) == 2'd0)
        |=> ($stable(init_q) && $stable(mux1_q) && $stable(mux4_q) && $stable(mode1_q)
             && $stable(gx_q) && $stable(gr_q) && $stable(ger_q) && $stable(stg_q)));

endmodule

// File: rtl/ireg_irq.sv
module ireg_irq #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic            clr,
    input  logic            ints_off,
    output logic [NSRC-1:0] pending,
    output logic            irq
);

    logic [NSRC-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (clr ? '0 : pend_q) | src;
    end

    assign pending = pend_q;
    assign irq     = (|pend_q) & ~ints_off;

    // R8: a source high in any cycle, including a clearing read, is pending afterwards
    a_r8_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (|src) |=> ((pend_q & $past(src)) == $past(src)));

    // R7: a read with no new source leaves nothing pending
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && src == '0) |=> pend_q == '0);

endmodule

// File: rtl/ireg_port.sv
module ireg_port
    import ireg_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 3,
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] irq_src,
    output logic            irq_o,
    output logic [1:0]      pwr_mode,
    output logic            ints_off,
    output logic [3:0]      path_a,
    output logic [3:0]      path_b,
    output logic            bch_irq_en,
    output logic            rev_bb,
    output logic            rev_bc,
    output logic            alaw_sel,
    output logic            gx_en,
    output logic            gr_en,
    output logic            ger_en,
    output logic            stg_en,
    output logic            loop_en,
    output logic [2*DW-1:0] gain_tx,
    output logic [2*DW-1:0] gain_rx,
    output logic [2*DW-1:0] gain_er,
    output logic [2*DW-1:0] gain_st
);

    localparam logic [AW-1:0] OFS_CMD  = AW'(0);
    localparam logic [AW-1:0] OFS_DATA = AW'(1);

    logic cmd_wr, irq_rd, data_acc, data_wr, at_lo, at_hi;
    logic [7:0] sel_num;
    logic [DW-1:0] rd_byte, init_q, mux1_q, mux4_q, mode1_q;
    logic [NSRC-1:0] pending;

    assign cmd_wr   = bus_sel &  bus_wr & (bus_addr == OFS_CMD);
    assign irq_rd   = bus_sel & ~bus_wr & (bus_addr == OFS_CMD);
    assign data_acc = bus_sel & (bus_addr == OFS_DATA);
    assign data_wr  = data_acc & bus_wr;

    ireg_fsm #(.NUMW(8)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_acc(data_acc),
        .cmd_val(bus_wdata[7:0]), .sel_num(sel_num), .at_lo(at_lo), .at_hi(at_hi)
    );

    ireg_file #(.DW(DW)) u_file (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(data_wr & at_lo), .wr_hi(data_wr & at_hi),
        .at_lo(at_lo), .at_hi(at_hi), .num(sel_num), .wdata(bus_wdata),
        .rd_byte(rd_byte), .init_q(init_q), .mux1_q(mux1_q), .mux4_q(mux4_q),
        .mode1_q(mode1_q), .gx_q(gain_tx), .gr_q(gain_rx), .ger_q(gain_er), .stg_q(gain_st)
    );

    ireg_irq #(.NSRC(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .src(irq_src), .clr(irq_rd),
        .ints_off(init_q[2]), .pending(pending), .irq(irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (irq_rd)                   bus_rdata = DW'(pending);
        else if (data_acc && !bus_wr) bus_rdata = rd_byte;
    end

    assign pwr_mode   = init_q[1:0];
    assign ints_off   = init_q[2];
    assign path_a     = mux1_q[3:0];
    assign path_b     = mux1_q[7:4];
    assign bch_irq_en = mux4_q[3];
    assign rev_bb     = mux4_q[4];
    assign rev_bc     = mux4_q[5];
    assign alaw_sel   = mode1_q[0];
    assign gx_en      = mode1_q[1];
    assign gr_en      = mode1_q[2];
    assign ger_en     = mode1_q[3];
    assign stg_en     = mode1_q[6];
    assign loop_en    = mode1_q[7];

    // R9: a set disable bit keeps the request low
    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ints_off |-> !irq_o);

    // R14: an unused offset changes no output
    a_r14_unused_ofs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr > OFS_DATA)
        |=> ($stable(gain_tx) && $stable(gain_rx) && $stable(gain_er) && $stable(gain_st)
             && $stable(pwr_mode) && $stable(path_a) && $stable(path_b)));

endmodule

// File: tb/ireg_port_bench.sv
module ireg_port_bench;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata, irq_src = '0;
    logic irq_o, ints_off, bch_irq_en, rev_bb, rev_bc, alaw_sel, gx_en, gr_en, ger_en, stg_en, loop_en;
    logic [1:0] pwr_mode;
    logic [3:0] path_a, path_b;
    logic [15:0] gain_tx, gain_rx, gain_er, gain_st;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    int mreg [256];
    int msel = -1;
    int mptr = 0;
    int mpend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ireg_port u_ireg_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_o(irq_o),
        .pwr_mode(pwr_mode), .ints_off(ints_off), .path_a(path_a), .path_b(path_b),
        .bch_irq_en(bch_irq_en), .rev_bb(rev_bb), .rev_bc(rev_bc), .alaw_sel(alaw_sel),
        .gx_en(gx_en), .gr_en(gr_en), .ger_en(ger_en), .stg_en(stg_en), .loop_en(loop_en),
        .gain_tx(gain_tx), .gain_rx(gain_rx), .gain_er(gain_er), .gain_st(gain_st)
    );

    function automatic int width_of(int r);
        if (r == 'h21 || r == 'h41 || r == 'h44 || r == 'h69) return 1;
        if (r >= 'h63 && r <= 'h66) return 2;
        return 0;
    endfunction

    task automatic chk(string req, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic compare_all();
        int i0, m1, m4, md;
        i0 = mreg['h21]; m1 = mreg['h41]; m4 = mreg['h44]; md = mreg['h69];
        chk("R9 irq_o", int'(irq_o), (mpend != 0 && (i0 & 4) == 0) ? 1 : 0);
        chk("R10 pwr_mode", int'(pwr_mode), i0 & 3);
        chk("R10 ints_off", int'(ints_off), (i0 >> 2) & 1);
        chk("R11 path_a", int'(path_a), m1 & 15);
        chk("R11 path_b", int'(path_b), (m1 >> 4) & 15);
        chk("R12 mux4 bits", int'({rev_bc, rev_bb, bch_irq_en}), (m4 >> 3) & 7);
        chk("R13 mode bits", int'({loop_en, stg_en, ger_en, gr_en, gx_en, alaw_sel}),
            (((md >> 6) & 3) << 4) | (md & 15));
        chk("R3 gain_tx", int'(gain_tx), mreg['h63]);
        chk("R3 gain_rx", int'(gain_rx), mreg['h64]);
        chk("R3 gain_er", int'(gain_er), mreg['h65]);
        chk("R3 gain_st", int'(gain_st), mreg['h66]);
    endtask

    // one bus access, read data checked in its own cycle, outputs checked the cycle after
    task automatic bus(bit wr, int a, int d, int src, string req);
        int exp;
        bus_sel = 1; bus_wr = wr; bus_addr = 3'(a); bus_wdata = 8'(d); irq_src = 8'(src);
        #1;
        if (!wr) begin
            if (a == 0) exp = mpend;
            else if (a == 1 && msel >= 0 && mptr < width_of(msel)) exp = (mreg[msel] >> (8*mptr)) & 'hff;
            else exp = 0;
            chk(req, int'(bus_rdata), exp);
        end
        @(posedge clk);
        if (a == 0 && wr) begin msel = d; mptr = 0; end
        if (a == 1 && msel >= 0) begin
            if (wr && mptr < width_of(msel)) begin
                if (mptr == 0) mreg[msel] = (mreg[msel] & 'hff00) | d;
                else           mreg[msel] = (mreg[msel] & 'h00ff) | (d << 8);
            end
            mptr++;
        end
        mpend = ((a == 0 && !wr) ? 0 : mpend) | src;
        @(negedge clk);
        bus_sel = 0; irq_src = 0;
        compare_all();
    endtask

    task automatic pulse(int src);
        irq_src = 8'(src);
        @(posedge clk);
        mpend = mpend | src;
        @(negedge clk);
        irq_src = 0;
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        foreach (mreg[i]) mreg[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare_all();                               // R1 reset state
        bus(0, 1, 0, 0, "R1 read before command");
        // R10 / R2: init register, write then read back
        bus(1, 0, 'h21, 0, "R2 cmd");
        bus(1, 1, 'h01, 0, "R10 init write");
        bus(1, 0, 'h21, 0, "R2 cmd");
        bus(0, 1, 0, 0, "R5 init read");
        bus(0, 1, 0, 0, "R4 read past end");
        // R11 mux channel codes
        bus(1, 0, 'h41, 0, "R11 cmd");
        bus(1, 1, 'h43, 0, "R11 write");
        // R12 mux control bits
        bus(1, 0, 'h44, 0, "R12 cmd");
        bus(1, 1, 'h38, 0, "R12 write");
        // R13 mode bits, surplus write ignored
        bus(1, 0, 'h69, 0, "R13 cmd");
        bus(1, 1, 'hCF, 0, "R13 write");
        bus(1, 1, 'h00, 0, "R4 write past end");
        // R3 two-byte gains
        bus(1, 0, 'h63, 0, "R3 cmd");
        bus(1, 1, 'h34, 0, "R3 low");
        bus(1, 1, 'h12, 0, "R3 high");
        bus(1, 1, 'h99, 0, "R4 third write");
        bus(1, 0, 'h63, 0, "R5 cmd");
        bus(0, 1, 0, 0, "R5 read low");
        bus(0, 1, 0, 0, "R5 read high");
        bus(0, 1, 0, 0, "R4 read past end 16");
        bus(1, 0, 'h64, 0, "R3 cmd");
        bus(1, 1, 'hA5, 0, "R3 low rx");
        bus(1, 1, 'h5A, 0, "R3 high rx");
        // R4 restart mid-transfer
        bus(1, 0, 'h65, 0, "R4 cmd");
        bus(1, 1, 'h11, 0, "R4 first low");
        bus(1, 0, 'h65, 0, "R4 recmd");
        bus(1, 1, 'h22, 0, "R4 restarted low");
        bus(1, 1, 'h33, 0, "R4 high");
        // R14 status read between bytes keeps the pointer
        bus(1, 0, 'h66, 0, "R14 cmd");
        bus(1, 1, 'h7E, 0, "R14 low");
        bus(0, 0, 0, 0, "R14 status read");
        bus(1, 1, 'hC3, 0, "R14 high after status");
        // R6 unknown register
        bus(1, 0, 'h70, 0, "R6 cmd");
        bus(1, 1, 'h55, 0, "R6 write");
        bus(0, 1, 0, 0, "R6 read");
        // R14 unused offsets
        bus(1, 3, 'hFF, 0, "R14 write ofs3");
        bus(0, 5, 0, 0, "R14 read ofs5");
        bus(0, 7, 0, 0, "R14 read ofs7");
        // R7 / R9 interrupts
        pulse('h10);
        pulse('h80);
        bus(0, 0, 0, 0, "R7 status read");
        bus(0, 0, 0, 0, "R7 cleared");
        // R8 source during read
        pulse('h04);
        bus(0, 0, 0, 'h01, "R8 read with source");
        bus(0, 0, 0, 0, "R8 kept pending");
        // R9 gating
        pulse('h20);
        bus(1, 0, 'h21, 0, "R9 cmd");
        bus(1, 1, 'h05, 0, "R9 disable");
        bus(1, 0, 'h21, 0, "R9 cmd");
        bus(1, 1, 'h02, 0, "R9 enable");
        bus(0, 0, 0, 0, "R9 clear");
        finish_run();
    end

endmodule